// File: doc/BRIEF.md
# Load-Use and Branch Stall Accounting Unit

This block is a timing monitor that sits beside an in-order pipeline and tallies stall cycles without taking part in execution. It watches each instruction at issue and remembers which general register, if any, that instruction loads. The next accepted instruction is then checked against that record. Every source operand that reads the loaded register is charged a fixed load-use penalty. Control-transfer instructions are classified as taken or untaken. A taken transfer is also charged a fixed redirect penalty.

Each instruction arrives on a single-cycle descriptor strobe. The descriptor carries up to two source register indices, each with its own valid flag, an optional load destination, a control-transfer flag and a taken flag. Four saturating counters report the running totals: load-stall cycles, branch-stall cycles, taken transfers and untaken transfers. All four counters and the scoreboard clear on a synchronous active-low reset. They hold their values in any cycle without a strobe.

Top module: `stall_monitor`

## Requirements
- R1: While `rst_n` is low at a clock edge, all four counters and the pending-load record clear to zero. After reset the counters read 0.
- R2: A valid load to register D records D. If the next accepted instruction has a valid source equal to D, the load-stall counter rises by 2 one clock after that instruction is accepted.
- R3: Each of the two source slots is checked on its own. If both hit the recorded register, even with the same index, the load-stall counter rises by 4.
- R4: A source whose valid flag is low never adds a stall, whatever its index.
- R5: A recorded load affects only the next accepted instruction. An accepted instruction without a load clears the record. An instruction's own load destination is not compared with its own sources, but a load instruction is itself checked against the previous load.
- R6: In a cycle where `issue_valid` is low, every counter and the load record keep their values, whatever the other inputs carry.
- R7: An accepted instruction with `cti` high and `cti_taken` high adds 2 to the branch-stall counter and 1 to the taken counter.
- R8: An accepted instruction with `cti` high and `cti_taken` low adds 1 to the untaken counter only. With `cti` low, `cti_taken` has no effect on any counter.
- R9: A control-transfer instruction is still checked for load-use hits on its sources, in the same cycle as its branch accounting.
- R10: Each counter is `CNT_W` bits wide (32 by default). A counter saturates at its all-ones value and never wraps, including when an increment of 2 or 4 would pass the maximum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| issue_valid | input | 1 | Descriptor strobe; one instruction accepted per high cycle |
| src0_valid | input | 1 | First source operand present |
| src0_idx | input | 4 | First source register index |
| src1_valid | input | 1 | Second source operand present |
| src1_idx | input | 4 | Second source register index |
| load_valid | input | 1 | Instruction is a load |
| load_dst | input | 4 | Load destination register |
| cti | input | 1 | Instruction is a control transfer |
| cti_taken | input | 1 | Control transfer was taken |
| load_stall_cycles | output | CNT_W (32) | Accumulated load-use stall cycles |
| branch_stall_cycles | output | CNT_W (32) | Accumulated taken-branch stall cycles |
| taken_count | output | CNT_W (32) | Number of taken control transfers |
| untaken_count | output | CNT_W (32) | Number of untaken control transfers |

## Verification
The bench checks the lifetime of the load record. A design that keeps the record alive too long charges a stall two instructions after a load. A design that clears the record on idle cycles misses a stall across a bubble. A design that compares a load with its own sources charges a stall that should not occur. The bench covers double hits on a single register, to catch designs that OR the two slots together. It sends sources with a low valid flag but a matching index, and a taken flag with no transfer. The counters are driven to saturation with increments of 2 and 4 starting just below the maximum, which exposes wraparound or a clamp that is off by one.

// File: rtl/stall_pkg.sv
`timescale 1ns/1ps
// Shared constants for the stall accounting unit.
// Assumes a 16-entry general register file and at most two source operands.
package stall_pkg;
    localparam int NUM_REGS  = 16;
    localparam int IDX_W     = $clog2(NUM_REGS);
    localparam int NUM_SRC   = 2;
    localparam int HIT_W     = $clog2(NUM_SRC + 1);
    localparam int LOAD_PEN  = 2;
    localparam int CTI_PEN   = 2;
    localparam int INC_W     = 4;

    typedef logic [IDX_W-1:0]    reg_idx_t;
    typedef logic [NUM_REGS-1:0] reg_mask_t;
endpackage

// File: rtl/load_scoreboard.sv
`timescale 1ns/1ps
// Load-use scoreboard: one bit per register marks the destination of the
// load accepted by the previous instruction. The bit stays set only until
// the next accepted instruction. Counts how many valid sources of the
// current instruction hit the marked register.
// Assumes a single instruction per strobe and in-order issue.
module load_scoreboard
    import stall_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          issue_valid,
    input  logic [NUM_SRC-1:0]            src_valid,
    input  logic [NUM_SRC-1:0][IDX_W-1:0] src_idx,
    input  logic                          load_valid,
    input  reg_idx_t                      load_dst,
    output logic [HIT_W-1:0]              hit_count
);
    reg_mask_t          active_mask;
    logic [NUM_SRC-1:0] src_hit;

    // Per-slot comparison of a source index against the marked register
    genvar g;
    generate
        for (g = 0; g < NUM_SRC; g++) begin : g_src
            assign src_hit[g] = src_valid[g] && active_mask[src_idx[g]];
        end
    endgenerate

    // Add up the hits across all source slots
    always_comb begin
        hit_count = '0;
        for (int i = 0; i < NUM_SRC; i++)
            hit_count = hit_count + HIT_W'(src_hit[i]);
    end

    // Move this instruction's load destination into the mask at the boundary
    always_ff @(posedge clk) begin
        if (!rst_n)
            active_mask <= '0;
        else if (issue_valid)
            active_mask <= load_valid ? (reg_mask_t'(1) << load_dst) : '0;
    end

    a_r2_mark_dst: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid && load_valid |=> active_mask[$past(load_dst)]);
    a_r5_single_mark: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(active_mask));
    a_r5_clear_without_load: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid && !load_valid |=> active_mask == '0);
    a_r6_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !issue_valid |=> $stable(active_mask));
endmodule

// File: rtl/sat_counter.sv
`timescale 1ns/1ps
// Saturating accumulator: adds a small increment when enabled and
// clamps at the all-ones value.
// Assumes INC_W <= CNT_W.
module sat_counter #(
    parameter int CNT_W = 32,
    parameter int INC_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc_en,
    input  logic [INC_W-1:0] inc,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] MAX_VAL = '1;

    logic [CNT_W:0] sum;

    // Widened sum so the carry-out shows an overflow
    always_comb sum = {1'b0, count} + (CNT_W+1)'(inc);

    // Accumulate, clamping at the maximum
    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= '0;
        else if (inc_en)
            count <= sum[CNT_W] ? MAX_VAL : sum[CNT_W-1:0];
    end

    a_r10_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        count == MAX_VAL |=> count == MAX_VAL);
    a_r10_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> count >= $past(count));
    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !inc_en |=> $stable(count));
endmodule

// File: rtl/stall_monitor.sv
`timescale 1ns/1ps
// Top of the stall accounting unit. It takes one instruction descriptor
// per strobe, charges load-use stalls from the scoreboard and branch
// penalties from the transfer flags, and keeps four saturating counters.
// Assumes the descriptor fields are meaningful only while issue_valid is high.
module stall_monitor
    import stall_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             issue_valid,
    input  logic             src0_valid,
    input  logic [3:0]       src0_idx,
    input  logic             src1_valid,
    input  logic [3:0]       src1_idx,
    input  logic             load_valid,
    input  logic [3:0]       load_dst,
    input  logic             cti,
    input  logic             cti_taken,
    output logic [CNT_W-1:0] load_stall_cycles,
    output logic [CNT_W-1:0] branch_stall_cycles,
    output logic [CNT_W-1:0] taken_count,
    output logic [CNT_W-1:0] untaken_count
);
    logic [HIT_W-1:0] hit_count;
    logic [INC_W-1:0] load_inc;
    logic             taken_ev;
    logic             untaken_ev;

    load_scoreboard u_sb (
        .clk         (clk),
        .rst_n       (rst_n),
        .issue_valid (issue_valid),
        .src_valid   ({src1_valid, src0_valid}),
        .src_idx     ({src1_idx, src0_idx}),
        .load_valid  (load_valid),
        .load_dst    (load_dst),
        .hit_count   (hit_count)
    );

    // Turn hit count into cycles, and decode the branch outcome
    always_comb begin
        load_inc   = INC_W'(hit_count) * INC_W'(LOAD_PEN);
        taken_ev   = issue_valid && cti && cti_taken;
        untaken_ev = issue_valid && cti && !cti_taken;
    end

    sat_counter #(.CNT_W(CNT_W), .INC_W(INC_W)) u_load_cnt (
        .clk (clk), .rst_n (rst_n), .inc_en (issue_valid),
        .inc (load_inc), .count (load_stall_cycles));

    sat_counter #(.CNT_W(CNT_W), .INC_W(INC_W)) u_br_cnt (
        .clk (clk), .rst_n (rst_n), .inc_en (taken_ev),
        .inc (INC_W'(CTI_PEN)), .count (branch_stall_cycles));

    sat_counter #(.CNT_W(CNT_W), .INC_W(INC_W)) u_tk_cnt (
        .clk (clk), .rst_n (rst_n), .inc_en (taken_ev),
        .inc (INC_W'(1)), .count (taken_count));

    sat_counter #(.CNT_W(CNT_W), .INC_W(INC_W)) u_ut_cnt (
        .clk (clk), .rst_n (rst_n), .inc_en (untaken_ev),
        .inc (INC_W'(1)), .count (untaken_count));

    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> load_stall_cycles == '0 && branch_stall_cycles == '0
                   && taken_count == '0 && untaken_count == '0);
    a_r7_taken_step: assert property (@(posedge clk) disable iff (!rst_n)
        taken_ev && taken_count != '1 |=> taken_count == $past(taken_count) + 1'b1);
    a_r8_no_cti_no_branch: assert property (@(posedge clk) disable iff (!rst_n)
        !(issue_valid && cti) |=> $stable(taken_count) && $stable(untaken_count)
                                  && $stable(branch_stall_cycles));
    a_r6_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !issue_valid |=> $stable(load_stall_cycles) && $stable(branch_stall_cycles));
endmodule

// File: tb/stall_monitor_tb.sv
`timescale 1ns/1ps
module stall_monitor_tb;
    localparam int W = 8;
    localparam int MAXV = (1 << W) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic issue_valid = 0, src0_valid = 0, src1_valid = 0, load_valid = 0;
    logic cti = 0, cti_taken = 0;
    logic [3:0] src0_idx = 0, src1_idx = 0, load_dst = 0;
    logic [W-1:0] load_stall_cycles, branch_stall_cycles, taken_count, untaken_count;

    int checks = 0, fails = 0;
    int m_ls = 0, m_bs = 0, m_tk = 0, m_ut = 0, m_mark = -1;

    always #4 clk = ~clk;

    stall_monitor #(.CNT_W(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid),
        .src0_valid(src0_valid), .src0_idx(src0_idx),
        .src1_valid(src1_valid), .src1_idx(src1_idx),
        .load_valid(load_valid), .load_dst(load_dst),
        .cti(cti), .cti_taken(cti_taken),
        .load_stall_cycles(load_stall_cycles), .branch_stall_cycles(branch_stall_cycles),
        .taken_count(taken_count), .untaken_count(untaken_count));

    function automatic int sat(input int v);
        return (v > MAXV) ? MAXV : v;
    endfunction

    task automatic check(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic compare_all(input string tag);
        check(tag, "load_stall", int'(load_stall_cycles), m_ls);
        check(tag, "branch_stall", int'(branch_stall_cycles), m_bs);
        check(tag, "taken", int'(taken_count), m_tk);
        check(tag, "untaken", int'(untaken_count), m_ut);
    endtask

    // One clock: drive descriptor, update the model at the edge, compare after it
    task automatic step(input string tag, input bit v,
                        input bit s0v, input int s0, input bit s1v, input int s1,
                        input bit lv, input int ld, input bit c, input bit t);
        int hits;
        issue_valid = v; src0_valid = s0v; src0_idx = 4'(s0);
        src1_valid = s1v; src1_idx = 4'(s1);
        load_valid = lv; load_dst = 4'(ld); cti = c; cti_taken = t;
        @(posedge clk);
        if (v) begin
            hits = ((s0v && s0 == m_mark) ? 1 : 0) + ((s1v && s1 == m_mark) ? 1 : 0);
            m_ls = sat(m_ls + 2 * hits);
            if (c && t) begin m_bs = sat(m_bs + 2); m_tk = sat(m_tk + 1); end
            else if (c) m_ut = sat(m_ut + 1);
            m_mark = lv ? ld : -1;
        end
        #1;
        compare_all(tag);
        @(negedge clk);
    endtask

    task automatic load_op(input string tag, input int dst);
        step(tag, 1, 0, 0, 0, 0, 1, dst, 0, 0);
    endtask

    task automatic use_op(input string tag, input bit s0v, input int s0, input bit s1v, input int s1);
        step(tag, 1, s0v, s0, s1v, s1, 0, 0, 0, 0);
    endtask

    initial begin
        #800000;
        fails++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        compare_all("R1");
        @(negedge clk);
        rst_n = 1'b1;

        // R2: single hit after a load
        load_op("R2", 3);
        use_op("R2", 1, 3, 0, 0);
        load_op("R2", 3);
        use_op("R2", 0, 0, 1, 3);
        // R3: both slots hitting, same register
        load_op("R3", 5);
        use_op("R3", 1, 5, 1, 5);
        // R4: invalid sources with matching index
        load_op("R4", 7);
        use_op("R4", 0, 7, 0, 7);
        // R5: gap instruction clears the mark; own destination not compared
        load_op("R5", 2);
        use_op("R5", 0, 0, 0, 0);
        use_op("R5", 1, 2, 1, 2);
        step("R5", 1, 1, 4, 0, 0, 1, 4, 0, 0);
        step("R5", 1, 1, 4, 1, 6, 1, 6, 0, 0);
        use_op("R5", 1, 4, 1, 6);
        // R6: bubbles hold the mark and counters
        load_op("R6", 9);
        step("R6", 0, 1, 9, 1, 9, 1, 1, 1, 1);
        step("R6", 0, 1, 1, 0, 0, 0, 0, 1, 0);
        use_op("R6", 1, 9, 0, 0);
        // R7 / R8: branch accounting
        step("R7", 1, 0, 0, 0, 0, 0, 0, 1, 1);
        step("R7", 1, 0, 0, 0, 0, 0, 0, 1, 1);
        step("R8", 1, 0, 0, 0, 0, 0, 0, 1, 0);
        step("R8", 1, 0, 0, 0, 0, 0, 0, 0, 1);
        // R9: taken transfer also pays load-use
        load_op("R9", 1);
        step("R9", 1, 1, 1, 0, 0, 0, 0, 1, 1);
        load_op("R9", 15);
        step("R9", 1, 0, 0, 1, 15, 0, 0, 1, 0);
        // R10: saturation with increments of 4, then of 2
        for (int i = 0; i < 70; i++) begin
            load_op("R10", 8);
            use_op("R10", 1, 8, 1, 8);
        end
        load_op("R10", 0);
        use_op("R10", 1, 0, 0, 0);
        for (int i = 0; i < 260; i++)
            step("R10", 1, 0, 0, 0, 0, 0, 0, 1, 1);
        for (int i = 0; i < 260; i++)
            step("R10", 1, 0, 0, 0, 0, 0, 0, 1, 0);
        check("R10", "load_stall_max", int'(load_stall_cycles), MAXV);
        check("R10", "taken_max", int'(taken_count), MAXV);
        // R1: reset mid-run clears everything including the mark
        load_op("R1", 11);
        rst_n = 1'b0;
        @(posedge clk); #1;
        m_ls = 0; m_bs = 0; m_tk = 0; m_ut = 0; m_mark = -1;
        compare_all("R1");
        @(negedge clk);
        rst_n = 1'b1;
        use_op("R1", 1, 11, 0, 0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule